// File: doc/BRIEF.md
# Execute Stage with Flag Register and Next-PC Selection

This block is the execute and program-counter update slice of a single-cycle processor. Each cycle it receives the decoded opcode, the function code, two register operands, the constant word taken from the instruction, the sequential next address and the word read from memory. It chooses the ALU operands for the instruction class and produces the ALU result. It holds a three-bit flag register and decides whether a conditional jump is taken. From all of this it selects the next program counter.

The flag register is the only state in the block. It is written at the rising clock edge, and only by arithmetic/logic instructions. Jump decisions within a cycle read the flags as they stand at the start of that cycle. Memory access and register write-back take place outside the block.

Top module: `exec_branch_unit`

## Requirements
- R1: Opcode 6 (arithmetic/logic) computes operand B combined with operand A according to the function code: 0 gives B+A, 1 gives B-A, 2 gives B AND A, 3 gives B XOR A. Function codes 4 to 15 give a result of zero.
- R2: Opcode 2 (register move) outputs operand A. Opcode 3 (immediate move) outputs the constant. Opcodes 4 and 5 (memory moves) output operand B plus the constant.
- R3: Opcodes 10 (push) and 8 (call) output operand B minus 4. Opcodes 11 (pop) and 9 (return) output operand B plus 4.
- R4: The flags change only at a clock edge where the opcode is 6. Under every other opcode they keep their value.
- R5: On an opcode-6 edge, the zero flag is set when the result is all zeros and the sign flag equals the result MSB. The overflow flag is signed overflow of B+A for function code 0 and of B-A for function code 1, and it is cleared for function codes 2 and 3.
- R6: The jump condition for function code f is: 0 always true, 1 (sign XOR overflow) OR zero, 2 sign XOR overflow, 3 zero, 4 NOT zero, 5 the inverse of code 2, 6 the inverse of code 1, and false for 7 to 15. The output takeBranch equals this condition when the opcode is 7 and is 0 for every other opcode.
- R7: For opcode 7 the next PC is the constant when the condition holds and the sequential address otherwise.
- R8: For opcode 8 the next PC is the constant. For opcode 9 it is the memory-read word. For every other opcode it is the sequential address.
- R9: A synchronous active-high reset sets the zero flag to 1 and clears the sign and overflow flags.
- R10: Opcodes 0, 1 and 7 give an ALU result of zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flag register |
| rst | input | 1 | Synchronous reset, active high |
| opCode | input | 4 | Instruction class |
| funCode | input | 4 | Function or jump condition code |
| valA | input | 32 | Register operand A |
| valB | input | 32 | Register operand B or stack pointer |
| valC | input | 32 | Instruction constant or target |
| valP | input | 32 | Sequential next address |
| memRet | input | 32 | Return address read from memory |
| aluOut | output | 32 | ALU result |
| ccZero | output | 1 | Zero flag |
| ccSign | output | 1 | Sign flag |
| ccOvf | output | 1 | Signed overflow flag |
| takeBranch | output | 1 | Jump condition met for a jump |
| newPc | output | 32 | Selected next program counter |

## Verification
A vector table walks every opcode, using operand values that are all different from one another. A wrong operand multiplexer therefore shows up as a wrong sum rather than a coincidental match. The flag register is then driven into five distinct states: zero, negative, clean positive, overflow on add and overflow on subtract. Under each state all sixteen jump codes are tried, which separates the signed comparisons from one another and from the zero tests. Non-arithmetic opcodes that yield a zero result are clocked between these steps to show that they leave the flags alone. A logic operation after an overflow shows that it clears the overflow flag.

// File: rtl/exec_pkg.sv
package exec_pkg;
  localparam logic [3:0] OP_NOP   = 4'h0;
  localparam logic [3:0] OP_HALT  = 4'h1;
  localparam logic [3:0] OP_RRMV  = 4'h2;
  localparam logic [3:0] OP_IRMV  = 4'h3;
  localparam logic [3:0] OP_RMMV  = 4'h4;
  localparam logic [3:0] OP_MRMV  = 4'h5;
  localparam logic [3:0] OP_ARITH = 4'h6;
  localparam logic [3:0] OP_JUMP  = 4'h7;
  localparam logic [3:0] OP_CALL  = 4'h8;
  localparam logic [3:0] OP_RET   = 4'h9;
  localparam logic [3:0] OP_PUSH  = 4'hA;
  localparam logic [3:0] OP_POP   = 4'hB;

  typedef enum logic [2:0] {A_REG, A_CONST, A_PLUS4, A_MINUS4, A_ZERO} aSel_e;
  typedef enum logic [1:0] {FN_ADD, FN_SUB, FN_AND, FN_XOR} aluFn_e;
  typedef enum logic [1:0] {PC_SEQ, PC_CONST, PC_COND, PC_RET} pcSel_e;

  typedef struct packed {
    aSel_e      aSel;
    logic       bZero;
    aluFn_e     aluFn;
    logic       killResult;
    logic       setCc;
    pcSel_e     pcSel;
    logic [3:0] condCode;
  } ctl_t;
endpackage

// File: rtl/exec_control.sv
module exec_control
  import exec_pkg::*;
(
  input  logic [3:0] opCode,
  input  logic [3:0] funCode,
  output ctl_t       ctl
);
  always_comb begin
    ctl = '{aSel: A_ZERO, bZero: 1'b1, aluFn: FN_ADD, killResult: 1'b0,
            setCc: 1'b0, pcSel: PC_SEQ, condCode: funCode};
    unique case (opCode)
      OP_RRMV: ctl.aSel = A_REG;
      OP_IRMV: ctl.aSel = A_CONST;
      OP_RMMV, OP_MRMV: begin
        ctl.aSel  = A_CONST;
        ctl.bZero = 1'b0;
      end
      OP_ARITH: begin
        ctl.aSel       = A_REG;
        ctl.bZero      = 1'b0;
        ctl.aluFn      = aluFn_e'(funCode[1:0]);
        ctl.killResult = (funCode > 4'd3);
        ctl.setCc      = 1'b1;
      end
      OP_JUMP: ctl.pcSel = PC_COND;
      OP_CALL: begin
        ctl.aSel  = A_MINUS4;
        ctl.bZero = 1'b0;
        ctl.pcSel = PC_CONST;
      end
      OP_RET: begin
        ctl.aSel  = A_PLUS4;
        ctl.bZero = 1'b0;
        ctl.pcSel = PC_RET;
      end
      OP_PUSH: begin
        ctl.aSel  = A_MINUS4;
        ctl.bZero = 1'b0;
      end
      OP_POP: begin
        ctl.aSel  = A_PLUS4;
        ctl.bZero = 1'b0;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/exec_datapath.sv
module exec_datapath
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  ctl_t         ctl,
  input  logic [W-1:0] valA,
  input  logic [W-1:0] valB,
  input  logic [W-1:0] valC,
  input  logic [W-1:0] valP,
  input  logic [W-1:0] memRet,
  output logic [W-1:0] aluOut,
  output logic         ccZero,
  output logic         ccSign,
  output logic         ccOvf,
  output logic         takeBranch,
  output logic [W-1:0] newPc
);
  localparam logic [W-1:0] STEP     = W'(4);
  localparam logic [W-1:0] NEG_STEP = ~STEP + W'(1);

  logic [W-1:0] opA, opB, rawRes;
  logic         rawOvf, condMet, lessThan;

  always_comb begin
    unique case (ctl.aSel)
      A_REG:    opA = valA;
      A_CONST:  opA = valC;
      A_PLUS4:  opA = STEP;
      A_MINUS4: opA = NEG_STEP;
      default:  opA = '0;
    endcase
    opB = ctl.bZero ? '0 : valB;
  end

  always_comb begin
    rawOvf = 1'b0;
    unique case (ctl.aluFn)
      FN_ADD: begin
        rawRes = opB + opA;
        rawOvf = (opA[W-1] == opB[W-1]) && (rawRes[W-1] != opB[W-1]);
      end
      FN_SUB: begin
        rawRes = opB - opA;
        rawOvf = (opA[W-1] != opB[W-1]) && (rawRes[W-1] != opB[W-1]);
      end
      FN_AND:  rawRes = opB & opA;
      default: rawRes = opB ^ opA;
    endcase
    if (ctl.killResult) begin
      rawRes = '0;
      rawOvf = 1'b0;
    end
  end

  assign aluOut = rawRes;

  always_ff @(posedge clk) begin
    if (rst) begin
      ccZero <= 1'b1;
      ccSign <= 1'b0;
      ccOvf  <= 1'b0;
    end else if (ctl.setCc) begin
      ccZero <= (rawRes == '0);
      ccSign <= rawRes[W-1];
      ccOvf  <= rawOvf;
    end
  end

  always_comb begin
    lessThan = ccSign ^ ccOvf;
    unique case (ctl.condCode)
      4'd0:    condMet = 1'b1;
      4'd1:    condMet = lessThan | ccZero;
      4'd2:    condMet = lessThan;
      4'd3:    condMet = ccZero;
      4'd4:    condMet = ~ccZero;
      4'd5:    condMet = ~lessThan;
      4'd6:    condMet = ~(lessThan | ccZero);
      default: condMet = 1'b0;
    endcase
  end

  assign takeBranch = condMet && (ctl.pcSel == PC_COND);

  always_comb begin
    unique case (ctl.pcSel)
      PC_CONST: newPc = valC;
      PC_RET:   newPc = memRet;
      PC_COND:  newPc = takeBranch ? valC : valP;
      default:  newPc = valP;
    endcase
  end

  a_r4_flags_hold: assert property (@(posedge clk) disable iff (rst)
    !ctl.setCc |=> $stable({ccZero, ccSign, ccOvf}));

  a_r7_taken_target: assert property (@(posedge clk) disable iff (rst)
    (ctl.pcSel == PC_COND && takeBranch) |-> newPc == valC);

  a_r7_fallthrough: assert property (@(posedge clk) disable iff (rst)
    (ctl.pcSel == PC_COND && !takeBranch) |-> newPc == valP);

  a_r8_call_target: assert property (@(posedge clk) disable iff (rst)
    (ctl.pcSel == PC_CONST) |-> newPc == valC);

  a_r8_return_addr: assert property (@(posedge clk) disable iff (rst)
    (ctl.pcSel == PC_RET) |-> newPc == memRet);

  a_r6_branch_only_jump: assert property (@(posedge clk) disable iff (rst)
    (ctl.pcSel != PC_COND) |-> !takeBranch);
endmodule

// File: rtl/exec_branch_unit.sv
module exec_branch_unit
  import exec_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [3:0]   opCode,
  input  logic [3:0]   funCode,
  input  logic [W-1:0] valA,
  input  logic [W-1:0] valB,
  input  logic [W-1:0] valC,
  input  logic [W-1:0] valP,
  input  logic [W-1:0] memRet,
  output logic [W-1:0] aluOut,
  output logic         ccZero,
  output logic         ccSign,
  output logic         ccOvf,
  output logic         takeBranch,
  output logic [W-1:0] newPc
);
  ctl_t ctl;

  exec_control u_ctrl (
    .opCode (opCode),
    .funCode(funCode),
    .ctl    (ctl)
  );

  exec_datapath #(.W(W)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .ctl       (ctl),
    .valA      (valA),
    .valB      (valB),
    .valC      (valC),
    .valP      (valP),
    .memRet    (memRet),
    .aluOut    (aluOut),
    .ccZero    (ccZero),
    .ccSign    (ccSign),
    .ccOvf     (ccOvf),
    .takeBranch(takeBranch),
    .newPc     (newPc)
  );
endmodule

// File: tb/exec_branch_unit_bench.sv
`timescale 1ns/1ps
module exec_branch_unit_bench;
  localparam int W = 32;

  typedef struct packed {
    logic [3:0]   op;
    logic [3:0]   fn;
    logic [W-1:0] a;
    logic [W-1:0] b;
    logic [W-1:0] c;
    logic [W-1:0] expAlu;
    logic [W-1:0] expPc;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{4'h6, 4'h0, 32'h5,      32'h7,        32'h3,     32'hC,      32'h40},
    '{4'h6, 4'h1, 32'h5,      32'h7,        32'h3,     32'h2,      32'h40},
    '{4'h6, 4'h2, 32'hF0F0,   32'hFF00,     32'h3,     32'hF000,   32'h40},
    '{4'h6, 4'h3, 32'hF0F0,   32'hFF00,     32'h3,     32'h0FF0,   32'h40},
    '{4'h6, 4'h9, 32'h5,      32'h7,        32'h3,     32'h0,      32'h40},
    '{4'h2, 4'h0, 32'h1234,   32'h99,       32'h77,    32'h1234,   32'h40},
    '{4'h3, 4'h0, 32'h1234,   32'h99,       32'hABCD,  32'hABCD,   32'h40},
    '{4'h4, 4'h0, 32'h11,     32'h100,      32'h20,    32'h120,    32'h40},
    '{4'h5, 4'h0, 32'h11,     32'hFFFFFFF0, 32'h20,    32'h10,     32'h40},
    '{4'hA, 4'h0, 32'h11,     32'h80,       32'h300,   32'h7C,     32'h40},
    '{4'h8, 4'h0, 32'h11,     32'h80,       32'h300,   32'h7C,     32'h300},
    '{4'hB, 4'h0, 32'h11,     32'h80,       32'h300,   32'h84,     32'h40},
    '{4'h9, 4'h0, 32'h11,     32'h80,       32'h300,   32'h84,     32'h88},
    '{4'h0, 4'h0, 32'h5,      32'h6,        32'h7,     32'h0,      32'h40},
    '{4'h1, 4'h0, 32'h5,      32'h6,        32'h7,     32'h0,      32'h40},
    '{4'h7, 4'h0, 32'h5,      32'h6,        32'h7,     32'h0,      32'h7}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [3:0] opCode = '0, funCode = '0;
  logic [W-1:0] valA = '0, valB = '0, valC = '0, valP = '0, memRet = '0;
  logic [W-1:0] aluOut, newPc;
  logic ccZero, ccSign, ccOvf, takeBranch;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  exec_branch_unit #(.W(W)) u_exec_branch_unit (
    .clk(clk), .rst(rst), .opCode(opCode), .funCode(funCode),
    .valA(valA), .valB(valB), .valC(valC), .valP(valP), .memRet(memRet),
    .aluOut(aluOut), .ccZero(ccZero), .ccSign(ccSign), .ccOvf(ccOvf),
    .takeBranch(takeBranch), .newPc(newPc)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] op, input logic [3:0] fn,
                       input logic [W-1:0] a, input logic [W-1:0] b,
                       input logic [W-1:0] c, input logic [W-1:0] p,
                       input logic [W-1:0] m);
    @(negedge clk);
    opCode = op; funCode = fn; valA = a; valB = b; valC = c; valP = p; memRet = m;
    #1;
  endtask

  function automatic logic condModel(input logic [3:0] fn, input logic z,
                                     input logic s, input logic o);
    case (fn)
      4'd0: return 1'b1;
      4'd1: return (s ^ o) | z;
      4'd2: return s ^ o;
      4'd3: return z;
      4'd4: return !z;
      4'd5: return !(s ^ o);
      4'd6: return !((s ^ o) | z);
      default: return 1'b0;
    endcase
  endfunction

  task automatic checkFlags(input string req, input logic z, input logic s, input logic o);
    check(req, {29'b0, ccZero, ccSign, ccOvf}, {29'b0, z, s, o});
  endtask

  task automatic flagState(input logic [3:0] fn, input logic [W-1:0] a, input logic [W-1:0] b,
                           input logic z, input logic s, input logic o);
    drive(4'h6, fn, a, b, 32'h0, 32'h40, 32'h0);
    @(posedge clk);
    drive(4'h0, 4'h0, 32'h0, 32'h0, 32'h0, 32'h40, 32'h0);
    checkFlags("R5 flags after arith", z, s, o);
    for (int f = 0; f < 16; f++) begin
      logic exp;
      exp = condModel(4'(f), z, s, o);
      drive(4'h7, 4'(f), 32'h1, 32'h2, 32'h200, 32'h48, 32'h99);
      check("R6 jump condition", {31'b0, takeBranch}, {31'b0, exp});
      check("R7 jump next PC", newPc, exp ? 32'h200 : 32'h48);
    end
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    checkFlags("R9 reset flags", 1'b1, 1'b0, 1'b0);
    rst = 1'b0;

    // Vector walk: R1, R2, R3, R8, R10 (flag-independent outputs)
    for (int i = 0; i < NV; i++) begin
      drive(VECS[i].op, VECS[i].fn, VECS[i].a, VECS[i].b, VECS[i].c, 32'h40, 32'h88);
      check($sformatf("R1/R2/R3/R10 alu vec %0d", i), aluOut, VECS[i].expAlu);
      check($sformatf("R8 next PC vec %0d", i), newPc, VECS[i].expPc);
    end

    // Flag states and every jump code under each: R5, R6, R7
    flagState(4'h0, 32'h1,        32'h1,        1'b0, 1'b0, 1'b0);
    flagState(4'h1, 32'h2,        32'h1,        1'b0, 1'b1, 1'b0);
    flagState(4'h0, 32'h1,        32'h7FFFFFFF, 1'b0, 1'b1, 1'b1);
    flagState(4'h3, 32'h0,        32'h80000000, 1'b0, 1'b1, 1'b0);
    flagState(4'h1, 32'h1,        32'h80000000, 1'b0, 1'b0, 1'b1);
    flagState(4'h1, 32'h1234,     32'h1234,     1'b1, 1'b0, 1'b0);

    // R4: non-arith ops with zero / negative results leave flags untouched
    drive(4'h3, 4'h0, 32'h0, 32'h0, 32'h80000000, 32'h40, 32'h0);
    @(posedge clk);
    drive(4'hA, 4'h0, 32'h0, 32'h4, 32'h0, 32'h40, 32'h0);
    @(posedge clk);
    drive(4'h7, 4'h0, 32'h0, 32'h0, 32'h0, 32'h40, 32'h0);
    @(posedge clk);
    drive(4'h0, 4'h0, 32'h0, 32'h0, 32'h0, 32'h40, 32'h0);
    checkFlags("R4 flags held", 1'b1, 1'b0, 1'b0);

    // R6: takeBranch stays low outside jumps even when code 0 is presented
    drive(4'h8, 4'h0, 32'h0, 32'h80, 32'h300, 32'h40, 32'h0);
    check("R6 no branch on call", {31'b0, takeBranch}, 32'h0);
    drive(4'h6, 4'h3, 32'h0, 32'h0, 32'h0, 32'h40, 32'h0);
    check("R6 no branch on arith", {31'b0, takeBranch}, 32'h0);

    // R9: reset mid-run after flags were moved
    flagState(4'h0, 32'h1, 32'h7FFFFFFF, 1'b0, 1'b1, 1'b1);
    drive(4'h6, 4'h1, 32'h1, 32'h0, 32'h0, 32'h40, 32'h0);
    rst = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    opCode = 4'h0;
    #1;
    checkFlags("R9 reset mid-run", 1'b1, 1'b0, 1'b0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule